// File: doc/BRIEF.md
# Two-CPU Interrupt Acknowledge Arbiter

This block keeps the pending and active state of 64 interrupt IDs that two CPU interfaces share, and answers each CPU's acknowledge read with the ID it should service. IDs 0 to 31 are per-CPU sources. Each CPU has its own input lines, its own pending bits and its own active bits for them, so both CPUs can take the same local ID independently. IDs 32 to 63 are shared sources. Each shared source is driven by a single line, and a target mask selects which CPUs it may be delivered to. Once any CPU takes a shared ID, no other CPU can take it until the owner deactivates it.

Each CPU reaches the block through a plain register port. A read at offset 0x0C acknowledges the best candidate. A write at 0x10 signals end of handling, and a write at 0x1000 deactivates an ID. Each ID can be configured as level or edge. A level source is pending for as long as its line is high, so acknowledging it does not clear it. An edge source latches a rising edge, and acknowledging it clears the latch. Each CPU has one IRQ output. It is high while that CPU can usefully acknowledge something.

The register port has no back-pressure. Each CPU may issue one access per cycle, a read or a write, and the port always accepts it. Read data returns with `bus_rvalid_o` exactly one cycle later.

Top module: `irq_ack_arbiter`

## Requirements
- R1: After reset both `irq_o` bits are 0, and an acknowledge read returns 1023.
- R2: A read at offset 0x0C returns, one cycle later with rvalid, the lowest-numbered ID that is eligible for that CPU, meaning pending and not active. A read at any other offset returns 0.
- R3: A CPU that acknowledges while nothing is eligible for it receives the spurious ID 1023, and no state changes.
- R4: IDs 0–31 are tracked separately per CPU. CPU c's line for local ID i is `local_lines_i[c*32+i]`, and one CPU acknowledging a local ID leaves the other CPU's copy pending.
- R5: After one CPU acknowledges a shared ID (32–63), that ID is no longer eligible for any CPU. The other CPU's IRQ for it drops in the same cycle that the read data returns.
- R6: If both CPUs acknowledge in the same cycle and CPU 0's pick is a shared ID, CPU 0 gets it. CPU 1 gets its next eligible ID, or 1023 if it has none.
- R7: Shared ID 32+k is eligible for CPU c only while `target_i[c*32+k]` is 1.
- R8: A level ID (`edge_cfg_i[id]`=0) is pending exactly while its line is high, and acknowledging it does not clear it. After deactivation with the line still high, the ID is signalled again to every targeted CPU.
- R9: An edge ID (`edge_cfg_i[id]`=1) becomes pending on a rising edge of its line and stays pending after the line falls. Acknowledging it clears the pending state.
- R10: After a successful acknowledge, the CPU's IRQ is low and its acknowledges return 1023 until it writes the same ID (`bus_wdata_i[c*10 +: 10]`) to offset 0x10. A write to 0x10 with any other ID is ignored.
- R11: A write to offset 0x1000 clears the active state of the written ID. A local ID is cleared for the writing CPU only. A shared ID is cleared only when the writer is the CPU that acknowledged it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_lines_i | input | 64 | Per-CPU lines for IDs 0–31; bit c*32+i |
| shared_lines_i | input | 32 | Shared lines; bit k is ID 32+k |
| edge_cfg_i | input | 64 | Per-ID trigger: 1 = edge, 0 = level |
| target_i | input | 64 | Shared target mask; bit c*32+k lets CPU c take ID 32+k |
| bus_rd_i | input | 2 | Read strobe per CPU |
| bus_wr_i | input | 2 | Write strobe per CPU |
| bus_addr_i | input | 26 | 13-bit offset per CPU |
| bus_wdata_i | input | 20 | 10-bit written ID per CPU |
| bus_rdata_o | output | 64 | 32-bit read data per CPU |
| bus_rvalid_o | output | 2 | Read data valid per CPU |
| irq_o | output | 2 | Interrupt request per CPU |

## Verification
The assertions assume that each CPU interface behaves like a well-formed register master. They assume it never issues a read and a write in the same cycle, and that it deactivates only IDs it has itself acknowledged and finished. Under those assumptions, two equal shared IDs returned in one cycle are always an error. The stimulus follows the same discipline. Every acknowledged ID receives an end-of-handling write and a deactivate from its owner before the next scenario starts. The one exception is a single deliberate deactivate from a non-owner, which checks that such a write is ignored. Lines change only on the falling clock edge, so edge detection sees each change once.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int CPU_COUNT = 2;
  localparam int ID_W = 10;
  localparam int AW = 13;
  localparam int DW = 32;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam logic [AW-1:0] OFS_ACK = 13'h00C;
  localparam logic [AW-1:0] OFS_EOI = 13'h010;
  localparam logic [AW-1:0] OFS_DEACT = 13'h1000;
endpackage

// File: rtl/irqarb_pick.sv
// Lowest-index set bit finder.
module irqarb_pick #(
  parameter int W = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqarb_cpu_port.sv
// Register decode and registered read data for one CPU interface.
module irqarb_cpu_port
  import irqarb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [ID_W-1:0] wdata,
  input  logic [ID_W-1:0] ack_id,
  output logic            ack_req,
  output logic            eoi_vld,
  output logic            deact_vld,
  output logic [ID_W-1:0] wid,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  assign ack_req   = rd && (addr == OFS_ACK);
  assign eoi_vld   = wr && (addr == OFS_EOI);
  assign deact_vld = wr && (addr == OFS_DEACT);
  assign wid       = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      rdata  <= ack_req ? DW'(ack_id) : '0;
    end
  end
endmodule

// File: rtl/irq_ack_arbiter.sv
module irq_ack_arbiter
  import irqarb_pkg::*;
#(
  parameter int NUM_LOCAL  = 32,
  parameter int NUM_SHARED = 32,
  localparam int NC  = CPU_COUNT,
  localparam int NI  = NUM_LOCAL + NUM_SHARED,
  localparam int IXW = $clog2(NI),
  localparam int LXW = $clog2(NUM_LOCAL),
  localparam int SXW = $clog2(NUM_SHARED)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NC*NUM_LOCAL-1:0] local_lines_i,
  input  logic [NUM_SHARED-1:0]   shared_lines_i,
  input  logic [NI-1:0]           edge_cfg_i,
  input  logic [NC*NUM_SHARED-1:0] target_i,
  input  logic [NC-1:0]           bus_rd_i,
  input  logic [NC-1:0]           bus_wr_i,
  input  logic [NC*AW-1:0]        bus_addr_i,
  input  logic [NC*ID_W-1:0]      bus_wdata_i,
  output logic [NC*DW-1:0]        bus_rdata_o,
  output logic [NC-1:0]           bus_rvalid_o,
  output logic [NC-1:0]           irq_o
);
  // per-CPU local state
  logic [NUM_LOCAL-1:0] lact [NC];
  logic [NUM_LOCAL-1:0] lpend_e [NC];
  logic [NUM_LOCAL-1:0] lline_q [NC];
  logic [NUM_LOCAL-1:0] lines_l [NC];
  logic [NUM_LOCAL-1:0] lpend [NC];
  // shared state; sowner bit = CPU that holds the ID
  logic [NUM_SHARED-1:0] sact, spend_e, sline_q, sowner, spend;
  logic [NC-1:0]         busy;
  logic [ID_W-1:0]       busy_id [NC];

  logic [NI-1:0]   elig [NC];
  logic [NI-1:0]   epick [NC];
  logic [NI-1:0]   steal;
  logic [NC-1:0]   found, gnt, take, ack_req, eoi_vld, deact_vld;
  logic [IXW-1:0]  pidx [NC];
  logic [IXW-1:0]  widx [NC];
  logic [ID_W-1:0] wid [NC];
  logic [ID_W-1:0] ack_id [NC];
  logic [NUM_LOCAL-1:0]  lset [NC];
  logic [NUM_LOCAL-1:0]  ldir [NC];
  logic [NUM_SHARED-1:0] sset [NC];
  logic [NUM_SHARED-1:0] sdir [NC];

  // eligibility and same-cycle steal mask
  always_comb begin
    spend = (edge_cfg_i[NI-1:NUM_LOCAL] & spend_e) |
            (~edge_cfg_i[NI-1:NUM_LOCAL] & shared_lines_i);
    for (int c = 0; c < NC; c++) begin
      lines_l[c] = local_lines_i[c*NUM_LOCAL +: NUM_LOCAL];
      lpend[c] = (edge_cfg_i[NUM_LOCAL-1:0] & lpend_e[c]) |
                 (~edge_cfg_i[NUM_LOCAL-1:0] & lines_l[c]);
      elig[c] = {spend & ~sact & target_i[c*NUM_SHARED +: NUM_SHARED],
                 lpend[c] & ~lact[c]};
      irq_o[c] = (|elig[c]) & ~busy[c];
    end
    steal = '0;
    if (ack_req[0] && found[0] && !busy[0] && (pidx[0] >= IXW'(NUM_LOCAL)))
      steal[pidx[0]] = 1'b1;
    epick[0] = elig[0];
    epick[1] = elig[1] & ~steal;
  end

  for (genvar c = 0; c < NC; c++) begin : g_cpu
    irqarb_pick #(.W(NI)) u_pick (
      .req(epick[c]), .found(found[c]), .idx(pidx[c])
    );
    irqarb_cpu_port u_port (
      .clk(clk), .rst_n(rst_n),
      .rd(bus_rd_i[c]), .wr(bus_wr_i[c]),
      .addr(bus_addr_i[c*AW +: AW]),
      .wdata(bus_wdata_i[c*ID_W +: ID_W]),
      .ack_id(ack_id[c]),
      .ack_req(ack_req[c]), .eoi_vld(eoi_vld[c]), .deact_vld(deact_vld[c]),
      .wid(wid[c]),
      .rdata(bus_rdata_o[c*DW +: DW]), .rvalid(bus_rvalid_o[c])
    );
  end

  // grant, set and clear masks
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      gnt[c]    = found[c] & ~busy[c];
      take[c]   = ack_req[c] & gnt[c];
      ack_id[c] = gnt[c] ? ID_W'(pidx[c]) : SPURIOUS_ID;
      lset[c] = '0;
      sset[c] = '0;
      ldir[c] = '0;
      sdir[c] = '0;
      if (take[c]) begin
        if (pidx[c] < IXW'(NUM_LOCAL)) lset[c][pidx[c][LXW-1:0]] = 1'b1;
        else sset[c][SXW'(pidx[c] - IXW'(NUM_LOCAL))] = 1'b1;
      end
      widx[c] = wid[c][IXW-1:0];
      if (deact_vld[c] && (wid[c] < ID_W'(NI))) begin
        if (widx[c] < IXW'(NUM_LOCAL)) ldir[c][widx[c][LXW-1:0]] = 1'b1;
        else sdir[c][SXW'(widx[c] - IXW'(NUM_LOCAL))] = 1'b1;
      end
      sdir[c] = sdir[c] & sact & ((c == 0) ? ~sowner : sowner);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        lact[c]    <= '0;
        lpend_e[c] <= '0;
        lline_q[c] <= '0;
        busy_id[c] <= '0;
      end
      busy    <= '0;
      sact    <= '0;
      spend_e <= '0;
      sline_q <= '0;
      sowner  <= '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        lline_q[c] <= lines_l[c];
        lact[c]    <= (lact[c] | lset[c]) & ~ldir[c];
        lpend_e[c] <= (lpend_e[c] & ~lset[c]) | (lines_l[c] & ~lline_q[c]);
        if (take[c]) begin
          busy[c]    <= 1'b1;
          busy_id[c] <= ack_id[c];
        end else if (eoi_vld[c] && busy[c] && (wid[c] == busy_id[c])) begin
          busy[c] <= 1'b0;
        end
      end
      sline_q <= shared_lines_i;
      sact    <= (sact | sset[0] | sset[1]) & ~(sdir[0] | sdir[1]);
      spend_e <= (spend_e & ~(sset[0] | sset[1])) | (shared_lines_i & ~sline_q);
      sowner  <= (sowner & ~sset[0]) | sset[1];
    end
  end
endmodule

// File: rtl/irq_ack_arbiter_checker.sv
module irq_ack_arbiter_checker
  import irqarb_pkg::*;
#(
  parameter int NI = 64,
  parameter int NUM_LOCAL = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            rd,
  input logic [2*AW-1:0]       addr,
  input logic [2*DW-1:0]       rdata,
  input logic [1:0]            rvalid,
  input logic [1:0]            irq,
  input logic [1:0]            busy
);
  // R5 R6: one shared ID never returned to both CPUs in one cycle
  a_r6_shared_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid == 2'b11 && rdata[31:0] >= NUM_LOCAL && rdata[31:0] < NI)
      |-> rdata[31:0] != rdata[63:32]);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    // R2: read data follows every read by one cycle
    a_r2_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
      rd[c] |=> rvalid[c]);
    // R10: a CPU holding an unfinished ID is not signalled
    a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy[c] |-> !irq[c]);
    // R10: acknowledges while holding an ID return spurious
    a_r10_busy_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[c] && rd[c] && addr[c*AW +: AW] == OFS_ACK)
        |=> (rdata[c*DW +: DW] == 32'd1023));
    // R3: returned values are a real ID or spurious
    a_r3_id_range: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid[c] |-> (rdata[c*DW +: DW] < NI || rdata[c*DW +: DW] == 32'd1023));
  end
endmodule

bind irq_ack_arbiter irq_ack_arbiter_checker #(.NI(NI), .NUM_LOCAL(NUM_LOCAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(bus_rd_i), .addr(bus_addr_i),
  .rdata(bus_rdata_o), .rvalid(bus_rvalid_o), .irq(irq_o), .busy(busy)
);

// File: tb/irq_ack_arbiter_test.sv
module irq_ack_arbiter_test;
  localparam int AW = 13;
  localparam int EOI = 16;
  localparam int DIR = 4096;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [63:0] lloc, ecfg, tgt;
  logic [31:0] shl;
  logic [1:0]  rd, wr;
  logic [2*AW-1:0] addr;
  logic [19:0] wdata;
  wire  [63:0] rdata;
  wire  [1:0]  rvalid, irq;

  irq_ack_arbiter uut (
    .clk(clk), .rst_n(rst_n), .local_lines_i(lloc), .shared_lines_i(shl),
    .edge_cfg_i(ecfg), .target_i(tgt), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  int n_cmp = 0, n_bad = 0;
  int expq0[$], expq1[$];
  string tagq0[$], tagq1[$];

  task automatic chk(string t, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic push(int c, int e, string t);
    if (c == 0) begin expq0.push_back(e); tagq0.push_back(t); end
    else begin expq1.push_back(e); tagq1.push_back(t); end
  endtask

  task automatic rd1(int c, int a, int e, string t);
    @(negedge clk);
    push(c, e, t);
    rd[c] = 1'b1;
    addr[c*AW +: AW] = AW'(a);
    @(negedge clk);
    rd[c] = 1'b0;
  endtask

  task automatic ack1(int c, int e, string t);
    rd1(c, 12, e, t);
  endtask

  task automatic ack2(int e0, int e1, string t);
    @(negedge clk);
    push(0, e0, t);
    push(1, e1, t);
    rd = 2'b11;
    addr = {13'h00C, 13'h00C};
    @(negedge clk);
    rd = 2'b00;
  endtask

  task automatic wr1(int c, int a, int id);
    @(negedge clk);
    wr[c] = 1'b1;
    addr[c*AW +: AW] = AW'(a);
    wdata[c*10 +: 10] = 10'(id);
    @(negedge clk);
    wr[c] = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (rvalid[c]) begin
          int e;
          string t;
          if ((c == 0 && expq0.size() == 0) || (c == 1 && expq1.size() == 0)) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2: unexpected response on cpu %0d actual %0d expected none",
                     c, rdata[c*32 +: 32]);
          end else begin
            if (c == 0) begin e = expq0.pop_front(); t = tagq0.pop_front(); end
            else begin e = expq1.pop_front(); t = tagq1.pop_front(); end
            chk($sformatf("%s cpu%0d ack", t, c), int'(rdata[c*32 +: 32]), e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lloc = '0; shl = '0; rd = '0; wr = '0; addr = '0; wdata = '0;
    ecfg = '0; ecfg[20] = 1'b1; ecfg[40] = 1'b1;
    tgt = '1; tgt[13] = 1'b0;          // ID 45 targets CPU 1 only
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R1 irq after reset", int'(irq), 0);
    ack1(0, 1023, "R1 R3 reset");
    rd1(0, 4, 0, "R2 other offset");

    // R4 local N-of-N, R10 busy, R8 level re-pend
    lloc[18] = 1'b1; lloc[32+18] = 1'b1;
    settle();
    chk("R4 both signalled", int'(irq), 3);
    ack1(0, 18, "R4");
    ack1(1, 18, "R4");
    chk("R10 busy irq low", int'(irq), 0);
    ack1(0, 1023, "R10 busy");
    wr1(0, EOI, 5);
    ack1(0, 1023, "R10 wrong eoi ignored");
    wr1(0, EOI, 18);
    chk("R8 active level no irq", int'(irq[0]), 0);
    ack1(0, 1023, "R8 ack did not re-pend");
    wr1(0, DIR, 18);
    chk("R8 R11 re-signal after deactivate", int'(irq[0]), 1);
    ack1(0, 18, "R8");
    wr1(0, EOI, 18);
    lloc[18] = 1'b0;
    wr1(0, DIR, 18);
    chk("R8 line low not pending", int'(irq[0]), 0);
    wr1(1, EOI, 18);
    lloc[32+18] = 1'b0;
    wr1(1, DIR, 18);
    chk("R4 cleanup", int'(irq), 0);

    // R2 lowest ID
    lloc[25] = 1'b1; lloc[19] = 1'b1;
    settle();
    ack1(0, 19, "R2 lowest");
    wr1(0, EOI, 19);
    lloc[19] = 1'b0;
    wr1(0, DIR, 19);
    ack1(0, 25, "R2 next");
    wr1(0, EOI, 25);
    lloc[25] = 1'b0;
    wr1(0, DIR, 25);
    chk("R2 cleanup", int'(irq), 0);

    // R5 shared one-of-N, R11 owner-only deactivate
    shl[1] = 1'b1;
    settle();
    chk("R5 both signalled", int'(irq), 3);
    ack1(1, 33, "R5");
    chk("R5 removed from other cpu", int'(irq), 0);
    ack1(0, 1023, "R5 other cpu blocked");
    wr1(1, EOI, 33);
    chk("R5 still active", int'(irq), 0);
    wr1(0, DIR, 33);
    ack1(0, 1023, "R11 non-owner deactivate ignored");
    wr1(1, DIR, 33);
    chk("R8 re-signal all targets", int'(irq), 3);
    shl[1] = 1'b0;
    settle();
    chk("R8 pending follows line", int'(irq), 0);

    // R6 same-cycle tie
    shl[2] = 1'b1; shl[4] = 1'b1;
    settle();
    ack2(34, 36, "R6 tie two ids");
    wr1(0, EOI, 34);
    wr1(1, EOI, 36);
    shl = '0;
    wr1(0, DIR, 34);
    wr1(1, DIR, 36);
    chk("R6 cleanup", int'(irq), 0);
    shl[3] = 1'b1;
    settle();
    ack2(35, 1023, "R6 tie one id");
    wr1(0, EOI, 35);
    shl[3] = 1'b0;
    wr1(0, DIR, 35);
    chk("R6 cleanup 2", int'(irq), 0);

    // R7 target mask
    shl[13] = 1'b1;
    settle();
    chk("R7 only cpu1 signalled", int'(irq), 2);
    ack1(0, 1023, "R7 untargeted");
    ack1(1, 45, "R7 targeted");
    wr1(1, EOI, 45);
    shl[13] = 1'b0;
    wr1(1, DIR, 45);
    chk("R7 cleanup", int'(irq), 0);

    // R9 edge, local and shared
    lloc[20] = 1'b1;
    settle();
    lloc[20] = 1'b0;
    settle();
    chk("R9 edge latched", int'(irq), 1);
    ack1(0, 20, "R9 local edge");
    wr1(0, EOI, 20);
    ack1(0, 1023, "R9 ack cleared edge");
    wr1(0, DIR, 20);
    chk("R9 no re-pend", int'(irq), 0);
    shl[8] = 1'b1;
    settle();
    shl[8] = 1'b0;
    settle();
    chk("R9 shared edge latched", int'(irq), 3);
    ack1(1, 40, "R9 shared edge");
    wr1(1, EOI, 40);
    ack1(0, 1023, "R9 shared cleared");
    wr1(1, DIR, 40);
    chk("R9 shared cleanup", int'(irq), 0);

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", expq0.size() + expq1.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule